// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a host request port and a parallel NOR flash device. A single request names one operation: return the device to read mode, read its identification words, run a common-flash-interface query, program one word, erase one block or erase the whole chip. The sequencer expands that request into the fixed series of bus cycles the device expects. Most operations begin with a two-cycle unlock pair. For the two query operations it also performs the read cycles and keeps the returned words.

The block drives a simple memory bus: address, write data, a write strobe, a read strobe and read data returned by the device. Each bus cycle lasts a programmable number of clocks. Command offsets are scaled to suit the device width, so a 16-bit device on a byte-addressed bus sees each offset doubled. A request that arrives while an operation is running is refused, and the running operation carries on.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset `busy`, `done`, `bus_we`, `bus_re`, `bus_addr`, `bus_wdata` and `rd_words` are all zero, and no strobe is ever asserted while `busy` is low.
- R2: Operation codes on `req_op`: 0 return-to-read, 1 identification read, 2 CFI query, 3 word program, 4 block erase, 5 chip erase. Codes 1, 3, 4 and 5 begin with the unlock pair: data 0xAA to command offset 0x555, then data 0x55 to offset 0x2AA.
- R3: A word program has four writes: the unlock pair, 0xA0 to offset 0x555, then `req_data` to `req_addr`.
- R4: A block erase has six writes: the unlock pair, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, and finally 0x30 to `req_addr`.
- R5: A chip erase repeats the first five block-erase writes. Its sixth write is 0x10 to offset 0x555.
- R6: An identification read has three writes (the unlock pair and 0x90 to 0x555), followed by four reads at offsets 0x00, 0x01, 0x0E and 0x0F. The word read at the k-th of these offsets is stored in `rd_words[16k+15:16k]`.
- R7: A CFI query is one write of 0x98 to offset 0x55, with no unlock pair, followed by four reads at offsets 0x10 to 0x13. These are stored in slots 0 to 3 of `rd_words` in the same way.
- R8: Return-to-read is one write of 0xF0 to `base_addr` itself.
- R9: The bus address of a command or read offset is `base_addr + offset` when `wide16` is 0, and `base_addr + 2*offset` when `wide16` is 1. `req_addr` is used without scaling.
- R10: Each bus cycle lasts `wait_cfg + 3` clocks. Address and data hold steady for the whole cycle. The strobe is high for `wait_cfg + 1` clocks, starting on the cycle's second clock. Read data is sampled on the last strobe clock. The two strobes are never high together.
- R11: On the clock after the last bus cycle ends, `done` is high for exactly one clock, `busy` is low, and `rd_words` holds the captured words. A run of n cycles keeps `busy` high for exactly n*(`wait_cfg`+3) clocks.
- R12: While `busy` is high, a `req_valid` raises `req_reject` in that same clock and leaves the running bus sequence unchanged. A code of 6 or 7 while idle also raises `req_reject`, and it starts no bus activity and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one clock |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Program target or erase block address |
| req_data | input | DATA_W | Word to program |
| base_addr | input | ADDR_W | Device base address |
| wide16 | input | 1 | 1 selects a 16-bit device |
| wait_cfg | input | WAIT_W | Extra strobe clocks per bus cycle |
| req_reject | output | 1 | Request refused |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock completion pulse |
| rd_words | output | 4*DATA_W | Captured identification or CFI words |
| bus_addr | output | ADDR_W | Memory bus address |
| bus_wdata | output | DATA_W | Memory bus write data |
| bus_we | output | 1 | Write strobe |
| bus_re | output | 1 | Read strobe |
| bus_rdata | input | DATA_W | Memory bus read data |

## Verification
On every cycle the assertions check the following: the strobes never overlap, nothing is strobed while idle, address and data stay steady inside a bus cycle, the cycle counter stays within its bound, `done` is a single clock that follows busy, and a refused request leaves the running operation in place. The exact command bytes, their order and their addresses under both device widths can only be shown by the bench scenarios. The same holds for the total length of each operation and for the words captured into each slot. The bench compares logged bus traffic against scripts it builds from the requirements, using random operations, widths, wait counts and addresses.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

    typedef enum logic [2:0] {
        OP_RESET     = 3'd0,
        OP_AUTOSEL   = 3'd1,
        OP_CFI       = 3'd2,
        OP_PROG      = 3'd3,
        OP_BLKERASE  = 3'd4,
        OP_CHIPERASE = 3'd5
    } op_e;

    typedef enum logic [1:0] {
        ASEL_CMD  = 2'd0,
        ASEL_BASE = 2'd1,
        ASEL_TGT  = 2'd2
    } asel_e;

    typedef struct packed {
        asel_e      asel;
        logic [11:0] off;
        logic [7:0]  cmd;
        logic        use_udata;
        logic        is_read;
        logic        last;
        logic [1:0]  slot;
    } step_t;

    function automatic step_t cmd_wr(logic [11:0] off, logic [7:0] cmd);
        step_t s;
        s = '0;
        s.asel = ASEL_CMD;
        s.off  = off;
        s.cmd  = cmd;
        return s;
    endfunction

    // One entry of the script for an operation at a given step index.
    function automatic step_t script_step(op_e op, logic [2:0] idx);
        step_t s;
        s = '0;
        case (op)
            OP_RESET: begin
                s.asel = ASEL_BASE;
                s.cmd  = 8'hF0;
                s.last = 1'b1;
            end
            OP_CFI: begin
                if (idx == 3'd0) begin
                    s = cmd_wr(12'h055, 8'h98);
                end else begin
                    s.is_read = 1'b1;
                    s.off     = 12'h00F + {9'd0, idx};
                    s.slot    = 2'(idx - 3'd1);
                    s.last    = (idx == 3'd4);
                end
            end
            OP_AUTOSEL: begin
                case (idx)
                    3'd0: s = cmd_wr(12'h555, 8'hAA);
                    3'd1: s = cmd_wr(12'h2AA, 8'h55);
                    3'd2: s = cmd_wr(12'h555, 8'h90);
                    default: begin
                        s.is_read = 1'b1;
                        s.slot    = 2'(idx - 3'd3);
                        s.last    = (idx == 3'd6);
                        case (idx)
                            3'd3:    s.off = 12'h000;
                            3'd4:    s.off = 12'h001;
                            3'd5:    s.off = 12'h00E;
                            default: s.off = 12'h00F;
                        endcase
                    end
                endcase
            end
            OP_PROG: begin
                case (idx)
                    3'd0: s = cmd_wr(12'h555, 8'hAA);
                    3'd1: s = cmd_wr(12'h2AA, 8'h55);
                    3'd2: s = cmd_wr(12'h555, 8'hA0);
                    default: begin
                        s.asel      = ASEL_TGT;
                        s.use_udata = 1'b1;
                        s.last      = 1'b1;
                    end
                endcase
            end
            default: begin // both erase kinds
                case (idx)
                    3'd0: s = cmd_wr(12'h555, 8'hAA);
                    3'd1: s = cmd_wr(12'h2AA, 8'h55);
                    3'd2: s = cmd_wr(12'h555, 8'h80);
                    3'd3: s = cmd_wr(12'h555, 8'hAA);
                    3'd4: s = cmd_wr(12'h2AA, 8'h55);
                    default: begin
                        if (op == OP_CHIPERASE) begin
                            s = cmd_wr(12'h555, 8'h10);
                        end else begin
                            s.asel = ASEL_TGT;
                            s.cmd  = 8'h30;
                        end
                        s.last = 1'b1;
                    end
                endcase
            end
        endcase
        return s;
    endfunction

endpackage

// File: rtl/nor_script.sv
module nor_script
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  op_e               op,
    input  logic [2:0]        idx,
    input  logic              wide,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] tgt,
    input  logic [DATA_W-1:0] udata,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic              is_read,
    output logic              last,
    output logic [1:0]        slot
);
    localparam int OFF_W = 13;

    step_t             st;
    logic [OFF_W-1:0]  scaled;

    always_comb begin
        st     = script_step(op, idx);
        scaled = wide ? {st.off, 1'b0} : {1'b0, st.off};
        case (st.asel)
            ASEL_BASE: addr = base;
            ASEL_TGT:  addr = tgt;
            default:   addr = base + ADDR_W'(scaled);
        endcase
        wdata   = st.use_udata ? udata : DATA_W'(st.cmd);
        is_read = st.is_read;
        last    = st.last;
        slot    = st.slot;
    end

endmodule

// File: rtl/nor_cycle_timer.sv
module nor_cycle_timer #(
    parameter int WAIT_W = 4,
    localparam int CNT_W = WAIT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [WAIT_W-1:0] wait_len,
    output logic [CNT_W-1:0]  cnt,
    output logic              strobe_on,
    output logic              sample,
    output logic              cyc_end
);
    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] end_val;

    always_comb begin
        end_val   = {1'b0, wait_len} + CNT_W'(2);
        cyc_end   = run && (cnt_q == end_val);
        sample    = run && (cnt_q == end_val - CNT_W'(1));
        strobe_on = run && (cnt_q != '0) && (cnt_q != end_val);
        cnt_d     = (!run || cyc_end) ? '0 : cnt_q + CNT_W'(1);
        cnt       = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> cnt_q <= end_val); // R10

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_seq_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16,
    parameter int WAIT_W = 4,
    localparam int NWORDS = 4,
    localparam int CNT_W  = WAIT_W + 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [2:0]               req_op,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [DATA_W-1:0]        req_data,
    input  logic [ADDR_W-1:0]        base_addr,
    input  logic                     wide16,
    input  logic [WAIT_W-1:0]        wait_cfg,
    output logic                     req_reject,
    output logic                     busy,
    output logic                     done,
    output logic [NWORDS*DATA_W-1:0] rd_words,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [DATA_W-1:0]        bus_wdata,
    output logic                     bus_we,
    output logic                     bus_re,
    input  logic [DATA_W-1:0]        bus_rdata
);
    typedef struct packed {
        logic                     busy;
        op_e                      op;
        logic [2:0]               idx;
        logic [ADDR_W-1:0]        base;
        logic [ADDR_W-1:0]        tgt;
        logic [DATA_W-1:0]        udata;
        logic                     wide;
        logic [WAIT_W-1:0]        wlen;
        logic                     done;
        logic [NWORDS*DATA_W-1:0] words;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [ADDR_W-1:0] s_addr;
    logic [DATA_W-1:0] s_wdata;
    logic              s_read, s_last;
    logic [1:0]        s_slot;
    logic [CNT_W-1:0]  cyc_cnt;
    logic              strobe_on, sample, cyc_end;
    logic              legal, accept;

    nor_script #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) script_i (
        .op(seq_q.op), .idx(seq_q.idx), .wide(seq_q.wide),
        .base(seq_q.base), .tgt(seq_q.tgt), .udata(seq_q.udata),
        .addr(s_addr), .wdata(s_wdata), .is_read(s_read),
        .last(s_last), .slot(s_slot)
    );

    nor_cycle_timer #(.WAIT_W(WAIT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .run(seq_q.busy), .wait_len(seq_q.wlen),
        .cnt(cyc_cnt), .strobe_on(strobe_on), .sample(sample), .cyc_end(cyc_end)
    );

    always_comb begin
        legal      = (req_op <= 3'd5);
        accept     = req_valid && !seq_q.busy && legal;
        req_reject = req_valid && (seq_q.busy || !legal);

        seq_d      = seq_q;
        seq_d.done = 1'b0;
        if (seq_q.busy) begin
            if (sample && s_read)
                seq_d.words[int'(s_slot)*DATA_W +: DATA_W] = bus_rdata;
            if (cyc_end) begin
                if (s_last) begin
                    seq_d.busy = 1'b0;
                    seq_d.done = 1'b1;
                end else begin
                    seq_d.idx = seq_q.idx + 3'd1;
                end
            end
        end else if (accept) begin
            seq_d.busy  = 1'b1;
            seq_d.op    = op_e'(req_op);
            seq_d.idx   = 3'd0;
            seq_d.base  = base_addr;
            seq_d.tgt   = req_addr;
            seq_d.udata = req_data;
            seq_d.wide  = wide16;
            seq_d.wlen  = wait_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    always_comb begin
        busy      = seq_q.busy;
        done      = seq_q.done;
        rd_words  = seq_q.words;
        bus_addr  = seq_q.busy ? s_addr : '0;
        bus_wdata = (seq_q.busy && !s_read) ? s_wdata : '0;
        bus_we    = strobe_on && !s_read;
        bus_re    = strobe_on && s_read;
    end

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_we && !bus_re)); // R1
    AST_CYCLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cyc_cnt != '0) |-> ($stable(bus_addr) && $stable(bus_wdata))); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy))); // R11
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && req_valid && !(cyc_end && s_last)) |=>
            (busy && $stable(seq_q.op) && $stable(seq_q.tgt))); // R12

endmodule

// File: tb/nor_cmd_seq_tb.sv
module nor_cmd_seq_tb_top;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int WW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic [AW-1:0] base_addr = '0;
    logic          wide16 = 1'b0;
    logic [WW-1:0] wait_cfg = '0;
    logic          req_reject, busy, done, bus_we, bus_re;
    logic [4*DW-1:0] rd_words;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .WAIT_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .base_addr(base_addr),
        .wide16(wide16), .wait_cfg(wait_cfg), .req_reject(req_reject),
        .busy(busy), .done(done), .rd_words(rd_words), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [DW-1:0] mem_model(logic [AW-1:0] a);
        return a[15:0] ^ 16'hC35A;
    endfunction

    assign bus_rdata = bus_re ? mem_model(bus_addr) : 16'hDEAD;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected <150000", cyc);
                finish_run();
            end
        end
    end

    // expected script
    logic [AW-1:0] ea[8];
    logic [DW-1:0] ed[8];
    bit            er[8];
    int            e_n;
    // observed bus log
    logic [AW-1:0] la[8];
    logic [DW-1:0] ld[8];
    bit            lr[8];
    int            slen[8];
    int            nlog;

    function automatic logic [AW-1:0] caddr(logic [AW-1:0] b, bit w, int off);
        return b + (w ? AW'(off * 2) : AW'(off));
    endfunction

    task automatic add_w(logic [AW-1:0] a, logic [DW-1:0] d);
        ea[e_n] = a; ed[e_n] = d; er[e_n] = 1'b0; e_n++;
    endtask

    task automatic add_r(logic [AW-1:0] a);
        ea[e_n] = a; ed[e_n] = '0; er[e_n] = 1'b1; e_n++;
    endtask

    task automatic build_exp(int op, logic [AW-1:0] tgt, logic [DW-1:0] dat,
                             bit w, logic [AW-1:0] b);
        e_n = 0;
        if (op == 1 || op >= 3) begin // R2 unlock pair
            add_w(caddr(b, w, 'h555), 16'h00AA);
            add_w(caddr(b, w, 'h2AA), 16'h0055);
        end
        case (op)
            0: add_w(b, 16'h00F0); // R8
            1: begin // R6
                add_w(caddr(b, w, 'h555), 16'h0090);
                add_r(caddr(b, w, 'h00)); add_r(caddr(b, w, 'h01));
                add_r(caddr(b, w, 'h0E)); add_r(caddr(b, w, 'h0F));
            end
            2: begin // R7
                add_w(caddr(b, w, 'h55), 16'h0098);
                for (int k = 0; k < 4; k++) add_r(caddr(b, w, 'h10 + k));
            end
            3: begin // R3
                add_w(caddr(b, w, 'h555), 16'h00A0);
                add_w(tgt, dat);
            end
            default: begin // R4 R5
                add_w(caddr(b, w, 'h555), 16'h0080);
                add_w(caddr(b, w, 'h555), 16'h00AA);
                add_w(caddr(b, w, 'h2AA), 16'h0055);
                if (op == 4) add_w(tgt, 16'h0030);
                else         add_w(caddr(b, w, 'h555), 16'h0010);
            end
        endcase
    endtask

    function automatic string req_of(int op);
        case (op)
            0: return "R8";
            1: return "R6";
            2: return "R7";
            3: return "R3";
            4: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic run_op(int op, logic [AW-1:0] tgt, logic [DW-1:0] dat, bit w,
                          logic [AW-1:0] b, int wt, int inj_at);
        int  busy_cnt, done_cnt, ci, rd_k;
        bit  prev, stab_ok, seq_ok, len_ok;
        build_exp(op, tgt, dat, w, b);
        @(negedge clk);
        req_op = 3'(op); req_addr = tgt; req_data = dat; wide16 = w;
        base_addr = b; wait_cfg = WW'(wt); req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nlog = 0; busy_cnt = 0; done_cnt = 0; ci = 0; prev = 0; stab_ok = 1;
        while (ci < 2000) begin
            if (ci == inj_at) begin
                req_valid = 1'b1; req_op = 3'd5; req_addr = ~tgt;
                #1;
                chk(req_reject === 1'b1, "R12", "reject while busy", 64'(req_reject), 64'd1);
            end else if (ci == inj_at + 1) begin
                req_valid = 1'b0; req_op = 3'(op); req_addr = tgt;
            end
            if (busy) busy_cnt++;
            if (bus_we && bus_re) stab_ok = 0;
            if (bus_we || bus_re) begin
                if (!prev && nlog < 8) begin
                    la[nlog] = bus_addr; ld[nlog] = bus_wdata; lr[nlog] = bus_re;
                    slen[nlog] = 1; nlog++;
                end else if (prev) begin
                    slen[nlog-1]++;
                    if (bus_addr !== la[nlog-1] || bus_wdata !== ld[nlog-1]) stab_ok = 0;
                end
            end
            prev = bus_we || bus_re;
            if (done) begin
                done_cnt++;
                break;
            end
            @(negedge clk);
            ci++;
        end
        seq_ok = (nlog == e_n);
        len_ok = 1;
        for (int k = 0; k < e_n && k < nlog; k++) begin
            if (la[k] !== ea[k] || lr[k] !== er[k] || (!er[k] && ld[k] !== ed[k])) seq_ok = 0;
            if (slen[k] != wt + 1) len_ok = 0;
        end
        chk(seq_ok, req_of(op), "bus script", 64'(nlog), 64'(e_n));
        chk(len_ok && stab_ok, "R10", "strobe width/stability", 64'(slen[0]), 64'(wt + 1));
        chk(done_cnt == 1 && !busy, "R11", "done after run", 64'(done_cnt), 64'd1);
        chk(busy_cnt == e_n * (wt + 3), "R11", "busy clocks", 64'(busy_cnt), 64'(e_n * (wt + 3)));
        if (op == 1 || op == 2) begin
            rd_k = 0;
            for (int k = 0; k < e_n; k++) begin
                if (er[k]) begin
                    chk(rd_words[rd_k*DW +: DW] === mem_model(ea[k]), op == 1 ? "R6" : "R7",
                        "captured word", 64'(rd_words[rd_k*DW +: DW]), 64'(mem_model(ea[k])));
                    rd_k++;
                end
            end
        end
        @(negedge clk);
        chk(done === 1'b0, "R11", "done single clock", 64'(done), 64'd0);
    endtask

    initial begin
        #1;
        // R1 reset state
        chk(busy === 0 && done === 0 && bus_we === 0 && bus_re === 0 && bus_addr === '0
            && bus_wdata === '0 && rd_words === '0, "R1", "reset state",
            {busy, done, bus_we, bus_re}, 64'd0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 0 && bus_we === 0 && bus_re === 0, "R1", "idle after reset",
            {busy, bus_we, bus_re}, 64'd0);

        // directed: every op in both widths (R2 R9)
        for (int op = 0; op < 6; op++) begin
            run_op(op, 24'h12_3456, 16'hBEEF, 1'b0, 24'h40_0000, 0, -1);
            run_op(op, 24'h23_4568, 16'h1234, 1'b1, 24'h60_0000, 2, -1);
        end
        // R9 wide scaling on identification read, long wait
        run_op(1, 24'h0, 16'h0, 1'b1, 24'h10_0000, 15, -1);

        // R12 request during block erase
        run_op(4, 24'h33_0000, 16'h0, 1'b0, 24'h80_0000, 1, 5);
        // R12 request during read phase of CFI
        run_op(2, 24'h0, 16'h0, 1'b1, 24'h00_0000, 0, 7);

        // R12 illegal codes while idle
        for (int bad = 6; bad < 8; bad++) begin
            @(negedge clk);
            req_op = 3'(bad); req_valid = 1'b1;
            #1;
            chk(req_reject === 1'b1, "R12", "illegal code rejected", 64'(req_reject), 64'd1);
            @(negedge clk);
            req_valid = 1'b0;
            for (int k = 0; k < 4; k++) begin
                chk(!busy && !bus_we && !bus_re && !done, "R12", "illegal code idle",
                    {busy, bus_we, bus_re, done}, 64'd0);
                @(negedge clk);
            end
        end

        // constrained random
        void'($urandom(32'd20240611));
        for (int i = 0; i < 40; i++) begin
            run_op(int'($urandom % 6), AW'($urandom), DW'($urandom), 1'($urandom),
                   {8'($urandom), 16'h0}, int'($urandom % 4),
                   ($urandom % 3 == 0) ? int'($urandom % 6) + 1 : -1);
        end

        finish_run();
    end

endmodule